// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI master. It takes 32-bit words from an external transmit queue and shifts them out on a serial data line. At the same time it samples the return line and assembles the received bits into 32-bit words. Each received word carries a count of its valid bytes. The serial clock rate, polarity, sampling phase, bit order and frame length (1 to 32 bits) are set by static configuration inputs. The surrounding logic holds these inputs steady while a frame is in progress.

The transmit and receive paths can each be switched off. When only the receive path is on, the engine does not wait for transmit data. Instead it runs frames while a byte budget, loaded through a request port, is still above zero, and the budget shrinks as bytes arrive. Chip selects, the FIFO storage and any register interface are outside this block.

Top module: `spi_shift_engine`

## Requirements
- R1: Each serial clock half-period lasts `cfg_br + 1` module clock cycles, so the serial clock runs at module clock / (2 × (cfg_br + 1)).
- R2: `cfg_width` holds the frame length minus one. Each frame has exactly `cfg_width + 1` bits, from 1 to 32.
- R3: Between frames `sclk` rests at `cfg_cpol`. When `cfg_phase` = 1, the return line is sampled on the first edge of each bit and output data changes on the second edge. When `cfg_phase` = 0, output data changes on the first edge and sampling happens on the second edge.
- R4: When `cfg_msb_first` = 1, bit `cfg_width` of the word goes out first. When it is 0, bit 0 goes out first. Received bits are placed by the same rule, so the word is right-aligned in `rx_word`.
- R5: `cfg_tx_off` = 1 makes `mosi` carry the idle level and frames no longer wait on transmit data. `cfg_rx_off` = 1 suppresses `rx_word_valid`. With both set, no frame starts and nothing is popped.
- R6: When only receive is on, writing a non-zero count through `rx_req_wr` starts frames. Each frame takes from `rx_todo` the lesser of the remaining count and ceil(frame bits / 8). Frames stop when `rx_todo` reaches 0.
- R7: `mosi` equals `cfg_idle_level` between frames and for every bit of a receive-only frame.
- R8: `busy` is high from the cycle after a frame starts until its last clock edge, and low otherwise.
- R9: `rx_bytes_valid` is ceil(frame bits / 8), from 1 to 4. For the final, partial word of a receive-only request, it is the remaining count instead.
- R10: When transmit is on and `tx_valid` is low, no frame starts and `sclk` stays at `cfg_cpol`.
- R11: `tx_pop` is high for the one cycle in which a transmit frame starts. `rx_word_valid` is a one-cycle pulse in the cycle after a frame's last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_br | input | 16 | Half-period reload value |
| cfg_width | input | 5 | Frame bits minus one |
| cfg_cpol | input | 1 | Idle serial clock level |
| cfg_phase | input | 1 | 1: sample on first edge; 0: sample on second edge |
| cfg_msb_first | input | 1 | Bit order select |
| cfg_tx_off | input | 1 | Transmit path off |
| cfg_rx_off | input | 1 | Receive path off |
| cfg_idle_level | input | 1 | Level of `mosi` when no data is driven |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_data | input | 32 | Head word of the transmit queue |
| tx_pop | output | 1 | Head word consumed this cycle |
| rx_req_wr | input | 1 | Load the receive-only byte count |
| rx_req_bytes | input | 16 | Byte count to load |
| rx_todo | output | 16 | Remaining receive-only byte count |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Frame in progress |
| rx_word_valid | output | 1 | Received word available |
| rx_word | output | 32 | Received word, right-aligned |
| rx_bytes_valid | output | 3 | Valid low-order bytes in `rx_word` |

## Verification
The bench builds the engine with its default parameters: a 32-bit word, a 16-bit reload and a 16-bit byte counter. This makes the full-word case reachable, with four valid bytes, alongside 8-bit, 5-bit and 16-bit frames. The bench drives small reload values (0 to 2), so half-periods of one, two and three cycles can be measured within short frames. A receive-only request of 5 bytes on 16-bit frames leaves a remainder, which exercises the partial-word byte count and the countdown reaching zero.

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int WORD_W = 32,
  parameter int BR_W   = 16,
  parameter int CNT_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [BR_W-1:0]            cfg_br,
  input  logic [$clog2(WORD_W)-1:0]  cfg_width,
  input  logic                       cfg_cpol,
  input  logic                       cfg_phase,
  input  logic                       cfg_msb_first,
  input  logic                       cfg_tx_off,
  input  logic                       cfg_rx_off,
  input  logic                       cfg_idle_level,
  input  logic                       tx_valid,
  input  logic [WORD_W-1:0]          tx_data,
  output logic                       tx_pop,
  input  logic                       rx_req_wr,
  input  logic [CNT_W-1:0]           rx_req_bytes,
  output logic [CNT_W-1:0]           rx_todo,
  output logic                       sclk,
  output logic                       mosi,
  input  logic                       miso,
  output logic                       busy,
  output logic                       rx_word_valid,
  output logic [WORD_W-1:0]          rx_word,
  output logic [$clog2(WORD_W/8+1)-1:0] rx_bytes_valid
);
  localparam int IW = $clog2(WORD_W);
  localparam int EW = IW + 1;
  localparam int BW = $clog2(WORD_W/8+1);

  logic          run, done_q, sclk_r, mosi_r;
  logic          msb_q, ph_q, txon_q, rxon_q;
  logic [BR_W-1:0] div;
  logic [EW-1:0] edge_n;
  logic [IW-1:0] w_q;
  logic [WORD_W-1:0] tx_q, rx_q;
  logic [BW-1:0] bv_q;
  logic [CNT_W-1:0] todo;

  function automatic logic [IW-1:0] pos(input logic [IW-1:0] w, input logic msb,
                                        input logic [IW-1:0] i);
    return msb ? w - i : i;
  endfunction

  wire tx_on   = ~cfg_tx_off;
  wire rx_on   = ~cfg_rx_off;
  wire start   = ~run & ((tx_on & tx_valid) | (rx_on & ~tx_on & (todo != '0)));
  wire tick    = run & (div == '0);
  wire [IW-1:0] k = edge_n[EW-1:1];
  wire lead    = ~edge_n[0];
  wire last    = (edge_n == {w_q, 1'b1});
  wire [BW-1:0] per_frame = BW'(w_q >> 3) + 1'b1;
  wire rx_only_q = rxon_q & ~txon_q;
  wire [BW-1:0] bv_next = (rx_only_q && todo < CNT_W'(per_frame)) ? BW'(todo) : per_frame;
  wire [IW-1:0] k_next = k + 1'b1;
  wire bit_now  = txon_q ? tx_q[pos(w_q, msb_q, k)]      : cfg_idle_level;
  wire bit_next = txon_q ? tx_q[pos(w_q, msb_q, k_next)] : cfg_idle_level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; done_q <= 1'b0; sclk_r <= 1'b0; mosi_r <= 1'b1;
      msb_q <= 1'b0; ph_q <= 1'b0; txon_q <= 1'b0; rxon_q <= 1'b0;
      div <= '0; edge_n <= '0; w_q <= '0;
      tx_q <= '0; rx_q <= '0; bv_q <= '0; todo <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run) begin
        sclk_r <= cfg_cpol;
        mosi_r <= cfg_idle_level;
        if (start) begin
          run    <= 1'b1;
          div    <= cfg_br;
          edge_n <= '0;
          w_q    <= cfg_width;
          msb_q  <= cfg_msb_first;
          ph_q   <= cfg_phase;
          txon_q <= tx_on;
          rxon_q <= rx_on;
          tx_q   <= tx_data;
          rx_q   <= '0;
          if (tx_on && cfg_phase)
            mosi_r <= tx_data[pos(cfg_width, cfg_msb_first, '0)];
        end
      end else begin
        div <= tick ? cfg_br : div - 1'b1;
        if (tick) begin
          sclk_r <= ~sclk_r;
          edge_n <= edge_n + 1'b1;
          if (rxon_q && (ph_q == lead))
            rx_q[pos(w_q, msb_q, k)] <= miso;
          if (last) begin
            run    <= 1'b0;
            done_q <= rxon_q;
            mosi_r <= cfg_idle_level;
            bv_q   <= bv_next;
            if (rx_only_q) todo <= todo - CNT_W'(bv_next);
          end else if (ph_q && !lead) begin
            mosi_r <= bit_next;
          end else if (!ph_q && lead) begin
            mosi_r <= bit_now;
          end
        end
      end
      if (rx_req_wr) todo <= rx_req_bytes;
    end
  end

  assign tx_pop         = start & tx_on;
  assign busy           = run;
  assign sclk           = sclk_r;
  assign mosi           = mosi_r;
  assign rx_todo        = todo;
  assign rx_word_valid  = done_q;
  assign rx_word        = rx_q;
  assign rx_bytes_valid = bv_q;
endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk #(
  parameter int CNT_W = 16,
  parameter int BW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_cpol,
  input logic             cfg_tx_off,
  input logic             cfg_rx_off,
  input logic             tx_valid,
  input logic             tx_pop,
  input logic             busy,
  input logic             sclk,
  input logic             rx_word_valid,
  input logic [BW-1:0]    rx_bytes_valid,
  input logic             rx_req_wr,
  input logic [CNT_W-1:0] rx_todo
);
  p_pop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |-> !busy);
  p_pop_starts_r11: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |=> busy);
  p_rxv_after_frame_r11: assert property (@(posedge clk) disable iff (!rst_n) rx_word_valid |-> !busy);
  p_rxv_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n) rx_word_valid |=> !rx_word_valid);
  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $past(rst_n) && $stable(cfg_cpol)) |-> sclk == cfg_cpol);
  p_bv_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_valid |-> (rx_bytes_valid != '0 && rx_bytes_valid <= 3'd4));
  p_todo_nonincr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_req_wr |=> rx_todo <= $past(rx_todo));
  p_both_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_tx_off && cfg_rx_off && !busy) |=> !busy);
  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_tx_off && !tx_valid && !busy) |=> !busy);
endmodule

bind spi_shift_engine spi_shift_engine_chk #(.CNT_W(CNT_W), .BW($clog2(WORD_W/8+1))) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_tx_off(cfg_tx_off),
  .cfg_rx_off(cfg_rx_off), .tx_valid(tx_valid), .tx_pop(tx_pop), .busy(busy),
  .sclk(sclk), .rx_word_valid(rx_word_valid), .rx_bytes_valid(rx_bytes_valid),
  .rx_req_wr(rx_req_wr), .rx_todo(rx_todo));

// File: tb/sim_spi_shift_engine.sv
`timescale 1ns/1ps
module sim_spi_shift_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cfg_br = '0;
  logic [4:0]  cfg_width = 5'd7;
  logic cfg_cpol = 1'b0, cfg_phase = 1'b1, cfg_msb_first = 1'b1;
  logic cfg_tx_off = 1'b1, cfg_rx_off = 1'b1, cfg_idle_level = 1'b1;
  logic tx_valid;
  logic [31:0] tx_data;
  logic tx_pop;
  logic rx_req_wr = 1'b0;
  logic [15:0] rx_req_bytes = '0;
  logic [15:0] rx_todo;
  logic sclk, mosi, miso, busy, rx_word_valid;
  logic [31:0] rx_word;
  logic [2:0] rx_bytes_valid;

  always #2 clk = ~clk;

  spi_shift_engine u0 (.*);

  int total = 0, fails = 0;

  logic [31:0] q [16];
  int qh = 0, qt = 0;
  assign tx_valid = (qh < qt);
  assign tx_data  = q[qh % 16];
  always @(posedge clk) if (tx_pop) qh <= qh + 1;

  logic [31:0] s_word = '0, cap = '0;
  int s_c = 0, cap_i = 0, e_b = 1000;
  always @(posedge busy) begin e_b = 0; s_c = 0; cap = '0; cap_i = 0; end
  always @(sclk) begin
    if (e_b < 2 * (int'(cfg_width) + 1)) begin
      if ((sclk != cfg_cpol) != cfg_phase) s_c++;
      else begin
        cap[cfg_msb_first ? int'(cfg_width) - cap_i : cap_i] = mosi;
        cap_i++;
      end
      e_b++;
    end
  end
  always @* begin
    int idx;
    idx = cfg_phase ? s_c : s_c - 1;
    if (idx < 0 || idx > int'(cfg_width)) miso = 1'b0;
    else miso = cfg_msb_first ? s_word[int'(cfg_width) - idx] : s_word[idx];
  end

  logic [31:0] rx_w [8];
  logic [2:0]  rx_b [8];
  int rx_n = 0, pulse_bad = 0, run_len = 0, last_half = 0;
  logic prev_rv = 1'b0, prev_sclk = 1'b0;
  always @(negedge clk) begin
    if (rx_word_valid) begin
      rx_w[rx_n % 8] = rx_word; rx_b[rx_n % 8] = rx_bytes_valid; rx_n++;
      if (prev_rv) pulse_bad++;
    end
    prev_rv = rx_word_valid;
    if (sclk != prev_sclk) begin last_half = run_len; run_len = 1; end
    else run_len++;
    prev_sclk = sclk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_frame();
    int n = 0;
    while (!busy && n < 300) begin @(negedge clk); n++; end
    n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic setup(input int br, input int w, input logic cpol, input logic ph,
                       input logic msb, input logic txoff, input logic rxoff);
    @(negedge clk);
    cfg_br = 16'(br); cfg_width = 5'(w); cfg_cpol = cpol; cfg_phase = ph;
    cfg_msb_first = msb; cfg_tx_off = txoff; cfg_rx_off = rxoff;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] mask(input int w);
    return (w == 31) ? 32'hFFFF_FFFF : ((32'd1 << (w + 1)) - 1);
  endfunction

  task automatic t_reset();
    chk("R8 busy after reset", {31'd0, busy}, 32'd0);
    chk("R11 rx_word_valid after reset", {31'd0, rx_word_valid}, 32'd0);
    chk("R11 tx_pop after reset", {31'd0, tx_pop}, 32'd0);
    chk("R6 rx_todo after reset", {16'd0, rx_todo}, 32'd0);
  endtask

  task automatic t_duplex(input int br, input int w, input logic cpol, input logic ph,
                          input logic msb, input logic [31:0] txw, input logic [31:0] sw,
                          input logic [2:0] bv);
    int n0;
    setup(br, w, cpol, ph, msb, 1'b0, 1'b0);
    s_word = sw; n0 = rx_n;
    q[qt % 16] = txw; qt++;
    repeat (3) @(negedge clk);
    chk("R8 busy mid-frame", {31'd0, busy}, 32'd1);
    wait_frame();
    chk("R4 R2 R3 mosi word", cap & mask(w), txw & mask(w));
    chk("R11 one rx word", 32'(rx_n - n0), 32'd1);
    chk("R4 R9 rx word", rx_w[n0 % 8], sw & mask(w));
    chk("R9 byte count", {29'd0, rx_b[n0 % 8]}, {29'd0, bv});
    chk("R1 half period", 32'(last_half), 32'(br + 1));
    chk("R11 popped", 32'(qh), 32'(qt));
    chk("R3 sclk idle", {31'd0, sclk}, {31'd0, cpol});
  endtask

  task automatic t_tx_only();
    int n0;
    setup(1, 7, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    n0 = rx_n;
    q[qt % 16] = 32'h0000_003C; qt++;
    wait_frame();
    chk("R5 tx-only mosi", cap & 32'hFF, 32'h3C);
    chk("R5 rx off no word", 32'(rx_n - n0), 32'd0);
  endtask

  task automatic t_both_off();
    int h0;
    setup(0, 7, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    q[qt % 16] = 32'h55; qt++;
    h0 = qh;
    repeat (30) @(negedge clk);
    chk("R5 both off not busy", {31'd0, busy}, 32'd0);
    chk("R5 both off no pop", 32'(qh), 32'(h0));
    qh = qt;
  endtask

  task automatic t_stall();
    int bad = 0;
    setup(0, 7, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (busy || tx_pop || sclk != 1'b1) bad++;
    end
    chk("R10 stall cycles with activity", 32'(bad), 32'd0);
  endtask

  task automatic t_rx_only();
    int n0;
    setup(0, 15, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    cfg_idle_level = 1'b1;
    s_word = 32'h0000_A5C3;
    repeat (20) @(negedge clk);
    chk("R6 no request no frame", {31'd0, busy}, 32'd0);
    n0 = rx_n;
    rx_req_wr = 1'b1; rx_req_bytes = 16'd5;
    @(negedge clk);
    rx_req_wr = 1'b0;
    repeat (3) wait_frame();
    repeat (10) @(negedge clk);
    chk("R6 word count", 32'(rx_n - n0), 32'd3);
    chk("R9 rx-only word data", rx_w[n0 % 8], 32'h0000_A5C3);
    chk("R9 bv first", {29'd0, rx_b[n0 % 8]}, 32'd2);
    chk("R9 bv partial last", {29'd0, rx_b[(n0 + 2) % 8]}, 32'd1);
    chk("R6 todo drained", {16'd0, rx_todo}, 32'd0);
    chk("R7 rx-only mosi idle", cap & 32'hFFFF, 32'h0000_FFFF);
    chk("R6 stopped", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_idle_level();
    @(negedge clk);
    cfg_idle_level = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 idle level low", {31'd0, mosi}, 32'd0);
    cfg_idle_level = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 idle level high", {31'd0, mosi}, 32'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_duplex(0, 7, 1'b0, 1'b1, 1'b1, 32'h0000_00A6, 32'h0000_005B, 3'd1);
    t_duplex(2, 31, 1'b1, 1'b0, 1'b0, 32'hDEAD_BEEF, 32'h1234_5679, 3'd4);
    t_duplex(1, 4, 1'b0, 1'b0, 1'b1, 32'h0000_0013, 32'h0000_000A, 3'd1);
    t_tx_only();
    t_both_off();
    t_stall();
    t_rx_only();
    t_idle_level();
    chk("R11 pulse width", 32'(pulse_bad), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule